// File: doc/BRIEF.md
# I2C Master DMA Byte Mover

This block moves bytes between system memory and the byte engine of an I2C master, so software does not have to handle each byte. Software writes a buffer start address and a byte count into two registers. It then writes a command word with a transmit-DMA or receive-DMA enable bit set. The sequencer runs until the count reaches zero, the target refuses a byte, or memory reports an error. It then pulses `done` and clears the relevant command bits.

In transmit mode, each byte is read from memory and handed to the byte engine. When the command also carries the start bit, the first byte read from memory is the slave address byte, and it counts against the length like any data byte. In receive mode, each byte the engine delivers is written to memory at the current address. Only one memory request is outstanding at any time.

The sequencer states are S_IDLE, S_FETCH, S_SEND, S_RECV, S_STORE and S_FINISH. These are its transitions:

- S_IDLE goes to S_FETCH on a transmit start, or to S_RECV on a receive start. If the length is zero at start, it goes straight to S_FINISH.
- S_FETCH goes to S_SEND on a clean memory acknowledge, or to S_FINISH on a memory error.
- S_SEND goes to S_FETCH on an acknowledged byte while the count is nonzero. It goes to S_FINISH when the count is zero or the target NACKs.
- S_RECV goes to S_STORE when the engine delivers a byte.
- S_STORE goes back to S_RECV after a clean write while bytes remain. It goes to S_FINISH after the last byte or on a memory error.
- S_FINISH always returns to S_IDLE.

Top module: `i2c_dma_engine`

## Requirements
- R1: Register reads depend on the offset.
  - Offset 0x14 returns the 16 stored command bits in bits 15:0, with the `bus_busy` input at bit 16 and zeros above.
  - Offset 0x24 returns the buffer address and offset 0x28 returns the length.
  - Any other offset reads zero.
- R2: A write to the address register stores the written value with bits 1:0 forced to zero.
- R3: A write to the length register keeps only bits 11:0. A zero stored length sets `len_zero_err`, and a later nonzero length clears it.
- R4: Every byte moved in either direction raises the address by one and lowers the length by one. A failed memory access changes neither.
- R5: Transmit starts from a command write with bit 9 set and bit 0 or bit 1 set.
  - While the length is nonzero, each fetched byte is offered on `bus_tx_byte`.
  - A NACK ends the transfer at once and sets `err_status`.
  - Bit 9 is clear after the transfer ends.
- R6: With bit 0 set, the first fetched byte is the address byte and consumes one count.
  - Bit 1 stays set while bytes remain and is clear once the length is zero.
  - A length of one sends only that address byte.
- R7: Receive starts from a command write with bit 10 and bit 3 set (bit 9 clear).
  - Each received byte is written to memory at the current address.
  - At the end, bits 10 and 3 are clear and `err_status` is zero.
- R8: A memory error ends the transfer at once and sets `err_status`.
  - In receive mode, bit 10 stays set.
  - In transmit mode, no byte is sent for the failed fetch and bit 9 is cleared.
- R9: With `DMA_EN` = 0, the address and length registers read all ones and ignore writes. Command writes that set bit 9 or bit 10 are dropped whole, and no memory or bus activity ever occurs.
- R10: Reset clears the address, the length, the command and `err_status`.
- R11: `done` is high for exactly one cycle per transfer, including aborted ones. A transfer started with zero length finishes without any memory request.
- R12: The memory request holds `mem_addr` and `mem_we` stable until `mem_ack`, with one request outstanding at most. The bus send holds its byte until `bus_done`.
- R13: Register writes are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bus_busy | input | 1 | Bus-busy status shown at bit 16 of the command register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory error, valid with `mem_ack` |
| bus_send | output | 1 | Byte offered to the I2C byte engine, held until `bus_done` |
| bus_tx_byte | output | 8 | Byte to send |
| bus_recv | output | 1 | Request for one received byte, held until `bus_done` |
| bus_rx_byte | input | 8 | Received byte, valid with `bus_done` |
| bus_done | input | 1 | Byte engine finished the send or receive |
| bus_nack | input | 1 | Target did not acknowledge, valid with `bus_done` on a send |
| done | output | 1 | One-cycle pulse when a transfer ends |
| err_status | output | 1 | Sticky: the last transfer ended on NACK or memory error |
| len_zero_err | output | 1 | The stored length is zero from a length write |

## Verification
The bench checks these corner cases and the failure each one would expose:

- **Length of one with the start bit.** A design that treated the address byte as free would fetch a second byte. One that cleared the transmit bit early would stop before any data.
- **NACK in the middle of a stream.** A design that ignored the NACK would keep draining the buffer, which shows up as a wrong remaining length.
- **Memory error on a receive write.** This checks that the byte is not counted and the receive enable survives. A design that cleaned up as on a normal end would read back bit 10 clear.
- **Zero length at start, and writes during a running transfer.** A zero-length start that issued a memory request would be caught. Writes that were not ignored while busy would leave a changed address or command after the run.

// File: rtl/i2c_dma_pkg.sv
package i2c_dma_pkg;

    // command register bit positions
    localparam int CMD_START = 0;
    localparam int CMD_MTX   = 1;
    localparam int CMD_MRX   = 3;
    localparam int CMD_TXDMA = 9;
    localparam int CMD_RXDMA = 10;
    localparam int CMD_W     = 16;
    localparam int REG_W     = 32;

    // register offsets
    localparam logic [7:0] OFF_CMD  = 8'h14;
    localparam logic [7:0] OFF_ADDR = 8'h24;
    localparam logic [7:0] OFF_LEN  = 8'h28;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SEND,
        S_RECV,
        S_STORE,
        S_FINISH
    } dma_state_e;

endpackage

// File: rtl/i2c_dma_regs.sv
module i2c_dma_regs
    import i2c_dma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LW     = 12,
    parameter bit DMA_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bus_busy,
    input  logic              busy,
    input  logic              step,
    input  logic              fin,
    input  logic              fin_keep_rx,
    input  logic              fin_err,
    output logic [AW-1:0]     addr_q,
    output logic [LW-1:0]     len_q,
    output logic              start_tx,
    output logic              start_rx,
    output logic              err_q,
    output logic              len_bad_q
);

    logic [CMD_W-1:0] cmd_q;
    logic wr_cmd, wr_addr, wr_len, cmd_ok, tx_go;

    assign wr_cmd  = reg_we && !busy && (reg_addr == OFF_CMD);
    assign wr_addr = reg_we && !busy && (reg_addr == OFF_ADDR);
    assign wr_len  = reg_we && !busy && (reg_addr == OFF_LEN);
    assign cmd_ok  = DMA_EN || !(reg_wdata[CMD_TXDMA] || reg_wdata[CMD_RXDMA]);
    assign tx_go   = reg_wdata[CMD_TXDMA] && (reg_wdata[CMD_START] || reg_wdata[CMD_MTX]);

    assign start_tx = wr_cmd && cmd_ok && tx_go;
    assign start_rx = wr_cmd && cmd_ok && !tx_go &&
                      reg_wdata[CMD_RXDMA] && reg_wdata[CMD_MRX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd && cmd_ok) begin
            cmd_q <= reg_wdata[CMD_W-1:0];
        end else if (fin) begin
            cmd_q[CMD_START] <= 1'b0;
            cmd_q[CMD_MTX]   <= 1'b0;
            cmd_q[CMD_MRX]   <= 1'b0;
            cmd_q[CMD_TXDMA] <= 1'b0;
            if (!fin_keep_rx) cmd_q[CMD_RXDMA] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            len_bad_q <= 1'b0;
        end else begin
            if (start_tx || start_rx) err_q <= 1'b0;
            else if (fin && fin_err)  err_q <= 1'b1;
            if (DMA_EN && wr_len) len_bad_q <= (reg_wdata[LW-1:0] == '0);
        end
    end

    generate
        if (DMA_EN) begin : g_dma
            logic [AW-1:0] addr_r;
            logic [LW-1:0] len_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_r <= '0;
                    len_r  <= '0;
                end else begin
                    if (wr_addr)   addr_r <= {reg_wdata[AW-1:2], 2'b00};
                    else if (step) addr_r <= addr_r + 1'b1;
                    if (wr_len)    len_r  <= reg_wdata[LW-1:0];
                    else if (step) len_r  <= len_r - 1'b1;
                end
            end
            assign addr_q = addr_r;
            assign len_q  = len_r;
        end else begin : g_nodma
            logic unused_nodma;
            assign unused_nodma = ^{step, wr_addr};
            assign addr_q = '0;
            assign len_q  = '0;
        end
    endgenerate

    always_comb begin
        unique case (reg_addr)
            OFF_CMD:  reg_rdata = {{(REG_W-CMD_W-1){1'b0}}, bus_busy, cmd_q};
            OFF_ADDR: reg_rdata = DMA_EN ? REG_W'(addr_q) : '1;
            OFF_LEN:  reg_rdata = DMA_EN ? REG_W'(len_q)  : '1;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_dma_seq.sv
module i2c_dma_seq
    import i2c_dma_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic [LW-1:0] len_q,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [7:0]    mem_rdata,
    input  logic          bus_done,
    input  logic          bus_nack,
    input  logic [7:0]    bus_rx_byte,
    output logic          busy,
    output logic          step,
    output logic          fin,
    output logic          fin_keep_rx,
    output logic          fin_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    output logic          bus_send,
    output logic          bus_recv,
    output logic [7:0]    bus_tx_byte
);

    dma_state_e state, nxt;
    logic       nxt_err, nxt_keep;
    logic       err_r, keep_r;
    logic [7:0] byte_r;

    // next-state selection
    always_comb begin
        nxt      = state;
        nxt_err  = 1'b0;
        nxt_keep = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start_tx)      nxt = (len_q == '0) ? S_FINISH : S_FETCH;
                else if (start_rx) nxt = (len_q == '0) ? S_FINISH : S_RECV;
            end
            S_FETCH: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        nxt     = S_FINISH;
                        nxt_err = 1'b1;
                    end else begin
                        nxt = S_SEND;
                    end
                end
            end
            S_SEND: begin
                if (bus_done) begin
                    if (bus_nack) begin
                        nxt     = S_FINISH;
                        nxt_err = 1'b1;
                    end else if (len_q == '0) begin
                        nxt = S_FINISH;
                    end else begin
                        nxt = S_FETCH;
                    end
                end
            end
            S_RECV: begin
                if (bus_done) nxt = S_STORE;
            end
            S_STORE: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        nxt      = S_FINISH;
                        nxt_err  = 1'b1;
                        nxt_keep = 1'b1;
                    end else if (len_q == LW'(1)) begin
                        nxt = S_FINISH;
                    end else begin
                        nxt = S_RECV;
                    end
                end
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register and byte staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            err_r  <= 1'b0;
            keep_r <= 1'b0;
            byte_r <= '0;
        end else begin
            state <= nxt;
            if (nxt == S_FINISH) begin
                err_r  <= nxt_err;
                keep_r <= nxt_keep;
            end
            if (state == S_FETCH && mem_ack)  byte_r <= mem_rdata;
            if (state == S_RECV  && bus_done) byte_r <= bus_rx_byte;
        end
    end

    // outputs
    always_comb begin
        mem_req     = (state == S_FETCH) || (state == S_STORE);
        mem_we      = (state == S_STORE);
        bus_send    = (state == S_SEND);
        bus_recv    = (state == S_RECV);
        step        = mem_req && mem_ack && !mem_err;
        fin         = (state == S_FINISH);
        fin_err     = err_r;
        fin_keep_rx = keep_r;
        busy        = (state != S_IDLE);
        mem_wdata   = byte_r;
        bus_tx_byte = byte_r;
    end

endmodule

// File: rtl/i2c_dma_engine.sv
module i2c_dma_engine
    import i2c_dma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LW     = 12,
    parameter bit DMA_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          bus_busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          bus_send,
    output logic [7:0]    bus_tx_byte,
    output logic          bus_recv,
    input  logic [7:0]    bus_rx_byte,
    input  logic          bus_done,
    input  logic          bus_nack,
    output logic          done,
    output logic          err_status,
    output logic          len_zero_err
);

    logic          busy, step, fin, fin_keep_rx, fin_err, start_tx, start_rx;
    logic [LW-1:0] len_q;

    i2c_dma_regs #(.AW(AW), .LW(LW), .DMA_EN(DMA_EN)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .bus_busy    (bus_busy),
        .busy        (busy),
        .step        (step),
        .fin         (fin),
        .fin_keep_rx (fin_keep_rx),
        .fin_err     (fin_err),
        .addr_q      (mem_addr),
        .len_q       (len_q),
        .start_tx    (start_tx),
        .start_rx    (start_rx),
        .err_q       (err_status),
        .len_bad_q   (len_zero_err)
    );

    i2c_dma_seq #(.LW(LW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_tx    (start_tx),
        .start_rx    (start_rx),
        .len_q       (len_q),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .bus_done    (bus_done),
        .bus_nack    (bus_nack),
        .bus_rx_byte (bus_rx_byte),
        .busy        (busy),
        .step        (step),
        .fin         (fin),
        .fin_keep_rx (fin_keep_rx),
        .fin_err     (fin_err),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .bus_send    (bus_send),
        .bus_recv    (bus_recv),
        .bus_tx_byte (bus_tx_byte)
    );

    assign done = fin;

endmodule

// File: rtl/i2c_dma_engine_chk.sv
module i2c_dma_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic          bus_send,
    input logic          bus_recv,
    input logic          bus_done,
    input logic          bus_nack,
    input logic [7:0]    bus_tx_byte,
    input logic          done
);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_err) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r12_send_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_send && !bus_done) |=> (bus_send && $stable(bus_tx_byte)));

    a_r5_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_send && bus_done && bus_nack) |=> (done && !mem_req));

    a_r8_memerr_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (done && !mem_req && !bus_send && !bus_recv));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !mem_req && !bus_send && !bus_recv));

endmodule

bind i2c_dma_engine i2c_dma_engine_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .mem_addr    (mem_addr),
    .bus_send    (bus_send),
    .bus_recv    (bus_recv),
    .bus_done    (bus_done),
    .bus_nack    (bus_nack),
    .bus_tx_byte (bus_tx_byte),
    .done        (done)
);

// File: tb/i2c_dma_engine_tb_top.sv
module i2c_dma_engine_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic        bus_busy = 1'b0;
    logic [31:0] reg_rdata, n_rdata;
    logic        mem_req, mem_we, bus_send, bus_recv, done, err_status, len_zero_err;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, bus_tx_byte;
    logic [7:0]  mem_rdata, bus_rx_byte;
    logic        mem_ack, mem_err, bus_done, bus_nack;
    logic        n_mem_req, n_mem_we, n_bus_send, n_bus_recv, n_done, n_err, n_lze;
    logic [31:0] n_mem_addr;
    logic [7:0]  n_mem_wdata, n_tx_byte;

    i2c_dma_engine #(.AW(32), .LW(12), .DMA_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_busy(bus_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .bus_send(bus_send), .bus_tx_byte(bus_tx_byte), .bus_recv(bus_recv),
        .bus_rx_byte(bus_rx_byte), .bus_done(bus_done), .bus_nack(bus_nack),
        .done(done), .err_status(err_status), .len_zero_err(len_zero_err)
    );

    i2c_dma_engine #(.AW(32), .LW(12), .DMA_EN(1'b0)) dut_nodma_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(n_rdata), .bus_busy(bus_busy),
        .mem_req(n_mem_req), .mem_we(n_mem_we), .mem_addr(n_mem_addr), .mem_wdata(n_mem_wdata),
        .mem_rdata(8'h00), .mem_ack(1'b0), .mem_err(1'b0),
        .bus_send(n_bus_send), .bus_tx_byte(n_tx_byte), .bus_recv(n_bus_recv),
        .bus_rx_byte(8'h00), .bus_done(1'b0), .bus_nack(1'b0),
        .done(n_done), .err_status(n_err), .len_zero_err(n_lze)
    );

    int compared = 0;
    int mismatched = 0;
    bit reported = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        end
        $finish;
    endtask

    // behavioural memory image and reference model state
    logic [7:0] img [logic [31:0]];
    logic [31:0] m_addr = '0;
    int  m_len = 0;
    bit  running = 1'b0;
    int  mem_lat = 0, bus_lat = 0, mwait = 0, bwait = 0;
    int  nack_at = -1, merr_at = -1;
    int  memops = 0, sends = 0, recvs = 0, stores = 0, dones = 0;
    logic [7:0] exp_tx = '0, exp_rx = '0, first_sent = '0;

    function automatic logic [7:0] byte_at(logic [31:0] a);
        if (img.exists(a)) return img[a];
        return 8'(a * 3 + 32'h11);
    endfunction

    // responders and per-clock comparison
    initial begin
        mem_ack = 0; mem_err = 0; mem_rdata = 0;
        bus_done = 0; bus_nack = 0; bus_rx_byte = 0;
        forever begin
            @(negedge clk);
            mem_ack = 0; mem_err = 0; bus_done = 0; bus_nack = 0;
            if (done) dones++;
            chk(!n_mem_req && !n_bus_send && !n_bus_recv && !n_done, "R9 disabled instance stays quiet",
                {n_mem_req, n_bus_send, n_bus_recv, n_done}, 0);
            if (!running)
                chk(!mem_req && !bus_send && !bus_recv && !done, "R11 idle between transfers",
                    {mem_req, bus_send, bus_recv, done}, 0);
            if (mem_req) begin
                if (mwait < mem_lat) begin
                    mwait++;
                    chk(mem_addr == m_addr, "R12 held request address", mem_addr, m_addr);
                end else begin
                    mwait = 0;
                    chk(mem_addr == m_addr, "R4 request address", mem_addr, m_addr);
                    if (memops == merr_at) begin
                        mem_err = 1;
                    end else if (mem_we) begin
                        chk(mem_wdata == exp_rx, "R7 stored byte", mem_wdata, exp_rx);
                        img[mem_addr] = mem_wdata;
                        m_addr++; m_len--; stores++;
                    end else begin
                        mem_rdata = byte_at(mem_addr);
                        exp_tx = mem_rdata;
                        m_addr++; m_len--;
                    end
                    memops++;
                    mem_ack = 1;
                end
            end else begin
                mwait = 0;
            end
            if (bus_send) begin
                if (bwait < bus_lat) bwait++;
                else begin
                    bwait = 0;
                    chk(bus_tx_byte == exp_tx, "R5 sent byte", bus_tx_byte, exp_tx);
                    if (sends == nack_at) bus_nack = 1;
                    sends++;
                    bus_done = 1;
                end
            end else if (bus_recv) begin
                if (bwait < bus_lat) bwait++;
                else begin
                    bwait = 0;
                    bus_rx_byte = 8'hA0 + 8'(recvs);
                    exp_rx = bus_rx_byte;
                    recvs++;
                    bus_done = 1;
                end
            end else begin
                bwait = 0;
            end
        end
    end

    initial begin
        #(20 * 150000);
        compared++; mismatched++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] nd);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
        nd = n_rdata;
    endtask

    task automatic wait_done(input int d0);
        for (int i = 0; i < 5000 && dones == d0; i++) @(negedge clk);
        chk(dones == d0 + 1, "R11 one done per transfer", dones - d0, 1);
        @(posedge clk); #1;
        running = 1'b0;
        repeat (2) @(negedge clk);
        chk(dones == d0 + 1, "R11 done pulse count settled", dones - d0, 1);
    endtask

    task automatic run(input logic [31:0] a, input int n, input logic [31:0] cmd);
        int d0;
        wr(8'h24, a);
        wr(8'h28, n);
        m_addr = a; m_len = n;
        d0 = dones;
        @(negedge clk);
        running = 1'b1;
        reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = cmd;
        @(negedge clk);
        reg_we = 1'b0;
        wait_done(d0);
    endtask

    logic [31:0] v, nv;
    int s0, m0, r0, st0, d1;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state, R1 unmapped read
        rd(8'h24, v, nv); chk(v == 0, "R10 address after reset", v, 0);
        rd(8'h28, v, nv); chk(v == 0, "R10 length after reset", v, 0);
        rd(8'h14, v, nv); chk(v == 0, "R10 command after reset", v, 0);
        chk(err_status == 0, "R10 err_status after reset", err_status, 0);
        rd(8'h00, v, nv); chk(v == 0, "R1 unmapped offset reads zero", v, 0);

        // R2 alignment
        wr(8'h24, 32'h1000_0103);
        rd(8'h24, v, nv); chk(v == 32'h1000_0100, "R2 address low bits dropped", v, 32'h1000_0100);

        // R3 length width and zero flag
        wr(8'h28, 32'h0000_F005);
        rd(8'h28, v, nv); chk(v == 32'h5, "R3 length keeps 12 bits", v, 5);
        chk(len_zero_err == 0, "R3 nonzero length flag", len_zero_err, 0);
        wr(8'h28, 32'h0000_3000);
        chk(len_zero_err == 1, "R3 zero length flagged", len_zero_err, 1);
        wr(8'h28, 32'h3);
        chk(len_zero_err == 0, "R3 flag cleared by nonzero", len_zero_err, 0);

        // R1 busy bit
        bus_busy = 1'b1;
        rd(8'h14, v, nv); chk(v == 32'h0001_0000, "R1 bus busy at bit 16", v, 32'h0001_0000);
        bus_busy = 1'b0;

        // R11 zero length start
        m0 = memops;
        run(32'h200, 0, 32'h202);
        chk(memops == m0, "R11 zero length makes no request", memops - m0, 0);
        rd(8'h14, v, nv); chk(v == 0, "R11 command cleared after zero length", v, 0);

        // R5 R6 R4 transmit with address byte
        mem_lat = 2; bus_lat = 1; s0 = sends;
        run(32'h300, 5, 32'h203);
        chk(sends - s0 == 5, "R6 address byte plus four data bytes", sends - s0, 5);
        rd(8'h24, v, nv); chk(v == 32'h305, "R4 address after transmit", v, 32'h305);
        rd(8'h28, v, nv); chk(v == 0, "R4 length after transmit", v, 0);
        rd(8'h14, v, nv); chk(v == 0, "R5 transmit bits cleared", v, 0);
        chk(err_status == 0, "R5 no error on clean transmit", err_status, 0);

        // R6 length one
        mem_lat = 0; bus_lat = 0; s0 = sends;
        run(32'h400, 1, 32'h203);
        chk(sends - s0 == 1, "R6 length one sends only address", sends - s0, 1);
        rd(8'h14, v, nv); chk(v == 0, "R6 transmit bit cleared at zero", v, 0);

        // R5 NACK on third byte
        s0 = sends; nack_at = sends + 2; bus_lat = 2;
        run(32'h500, 6, 32'h203);
        nack_at = -1;
        chk(sends - s0 == 3, "R5 stop at NACK", sends - s0, 3);
        rd(8'h28, v, nv); chk(v == 3, "R5 length left after NACK", v, 3);
        rd(8'h24, v, nv); chk(v == 32'h503, "R5 address after NACK", v, 32'h503);
        chk(err_status == 1, "R5 NACK sets error", err_status, 1);
        rd(8'h14, v, nv); chk(v == 0, "R5 transmit bit cleared after NACK", v, 0);

        // R7 receive
        r0 = recvs; mem_lat = 1; bus_lat = 0;
        run(32'h600, 4, 32'h408);
        for (int i = 0; i < 4; i++) begin
            v = {24'h0, byte_at(32'h600 + i)};
            chk(v == 32'(8'hA0 + 8'(r0 + i)), "R7 memory contents", v, 32'(8'hA0 + 8'(r0 + i)));
        end
        rd(8'h14, v, nv); chk(v == 0, "R7 receive bits cleared", v, 0);
        chk(err_status == 0, "R7 error cleared by new start", err_status, 0);
        rd(8'h24, v, nv); chk(v == 32'h604, "R4 address after receive", v, 32'h604);

        // R8 memory error during receive
        st0 = stores; r0 = recvs; merr_at = memops + 2;
        run(32'h700, 5, 32'h408);
        merr_at = -1;
        chk(stores - st0 == 2, "R8 stores before error", stores - st0, 2);
        chk(recvs - r0 == 3, "R8 no receive after error", recvs - r0, 3);
        rd(8'h28, v, nv); chk(v == 3, "R8 failed write not counted", v, 3);
        rd(8'h24, v, nv); chk(v == 32'h702, "R8 address after error", v, 32'h702);
        rd(8'h14, v, nv); chk(v == 32'h400, "R8 receive enable kept", v, 32'h400);
        chk(err_status == 1, "R8 error flagged", err_status, 1);
        wr(8'h14, 32'h0);

        // R8 memory error on transmit fetch
        s0 = sends; merr_at = memops;
        run(32'h800, 3, 32'h202);
        merr_at = -1;
        chk(sends == s0, "R8 no send after fetch error", sends - s0, 0);
        rd(8'h28, v, nv); chk(v == 3, "R8 length after fetch error", v, 3);
        rd(8'h14, v, nv); chk(v == 0, "R8 transmit bit cleared", v, 0);
        chk(err_status == 1, "R8 fetch error flagged", err_status, 1);

        // R13 writes ignored while busy
        mem_lat = 3;
        wr(8'h24, 32'h900); wr(8'h28, 4);
        m_addr = 32'h900; m_len = 4; d1 = dones;
        @(negedge clk);
        running = 1'b1;
        reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h408;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (2) @(negedge clk);
        wr(8'h24, 32'hF00);
        wr(8'h28, 9);
        wr(8'h14, 32'h1);
        wait_done(d1);
        rd(8'h24, v, nv); chk(v == 32'h904, "R13 address write ignored", v, 32'h904);
        rd(8'h28, v, nv); chk(v == 0, "R13 length write ignored", v, 0);
        rd(8'h14, v, nv); chk(v == 0, "R13 command write ignored", v, 0);

        // R9 disabled instance
        rd(8'h24, v, nv); chk(nv == 32'hFFFF_FFFF, "R9 address reads ones", nv, 32'hFFFF_FFFF);
        rd(8'h28, v, nv); chk(nv == 32'hFFFF_FFFF, "R9 length reads ones", nv, 32'hFFFF_FFFF);
        chk(n_lze == 0, "R9 zero length ignored", n_lze, 0);
        wr(8'h14, 32'h3);
        rd(8'h14, v, nv); chk(nv == 32'h3, "R9 plain command accepted", nv, 3);
        wr(8'h14, 32'h600);
        rd(8'h14, v, nv); chk(nv == 32'h3, "R9 DMA command rejected", nv, 3);
        chk(v == 32'h600, "R1 command stored without start", v, 32'h600);
        wr(8'h14, 32'h0);

        repeat (3) @(negedge clk);
        report();
    end

endmodule